// File: doc/BRIEF.md
# Alternating Peak and Valley Tracker

This block watches a stream of 8-bit samples, as a decimation stage delivers them, and picks out the most recent valley and peak of the signal in turn. While it searches, it keeps a running candidate. A minimum candidate only moves down and a maximum candidate only moves up. The candidate is committed to an output register once the signal has moved back from it by a noise threshold. The threshold is larger when the gain stage runs at its highest amplification.

A committed valley starts a search for a peak, and a committed peak starts a search for a valley, so the output registers always hold recent turning points and never all-time extremes. Each committed value carries a valid tag. The tag is set only when an extremum of the opposite kind was committed earlier in the same run. A clear pulse, raised by the surrounding logic on initialization, recalibration or a gain change, empties everything and restarts the search.

Top module: `extremum_tracker`

## Requirements
- R1: After reset, and in the cycle after a cycle with `clr` high, `min_val` and `max_val` are 0x00, `min_ok` and `max_ok` are 0 and no strobe is high. A sample presented in the same cycle as `clr` is dropped.
- R2: The first sample accepted after reset or clear seeds both the valley candidate and the peak candidate, and either kind may commit first.
- R3: While a valley is sought, a sample below the candidate replaces it and a sample at or above the candidate leaves it unchanged. The peak candidate behaves the same way with the comparison reversed.
- R4: A valley commits when an accepted sample exceeds the valley candidate by at least the threshold. In the next cycle `min_val` holds the candidate and `min_stb` is high for one cycle.
- R5: A peak commits when an accepted sample lies below the peak candidate by at least the threshold. In the next cycle `max_val` holds the candidate and `max_stb` is high for one cycle.
- R6: The threshold is 0x30 when `gain_max` is 0 and 0x48 when `gain_max` is 1. It is taken from `gain_max` in the cycle the sample is accepted.
- R7: Commits alternate. After a valley commit, only a peak can commit next, and the reverse. The sample that commits one kind seeds the candidate of the other kind.
- R8: A commit's valid flag (`min_ok` or `max_ok`) is 1 only if an extremum of the opposite kind was committed since the last reset or clear. The first commit of a run is therefore flagged 0.
- R9: Threshold comparisons do not wrap: samples at 0x00 and 0xFF are compared by their true difference.
- R10: The value registers and valid flags change only on a commit or a clear. The strobes rise only in the cycle after `smp_vld` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Flush all extrema and restart the search |
| smp_vld | input | 1 | Sample strobe, one cycle per decimated sample |
| smp_data | input | 8 | Unsigned decimated sample |
| gain_max | input | 1 | Gain stage at maximum amplification (selects the larger threshold) |
| min_val | output | 8 | Last committed valley |
| min_ok | output | 1 | Last committed valley is valid |
| min_stb | output | 1 | One-cycle pulse when a valley commits |
| max_val | output | 8 | Last committed peak |
| max_ok | output | 1 | Last committed peak is valid |
| max_stb | output | 1 | One-cycle pulse when a peak commits |

## Verification
The tracker is driven with a run that starts on a rising slope and a run that starts on a falling slope, which shows that either kind can commit first and is flagged invalid. Sample steps of exactly the threshold and one below it are used under both gain settings, which separates an off-by-one comparison from a wrong threshold choice. A swing between 0x00 and 0xFF exposes any wrap-around in the difference. A clear that coincides with a sample shows whether stale extrema or a dropped seed survive the flush.

// File: rtl/xtrk_pkg.sv
package xtrk_pkg;
    localparam int unsigned SAMPLE_W = 8;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        PH_EMPTY,
        PH_BOTH,
        PH_SEEK_MIN,
        PH_SEEK_MAX
    } phase_e;

    typedef struct packed {
        logic    hit_min;
        logic    hit_max;
        sample_t val;
    } commit_t;

    // True when upper - lower >= thr, evaluated one bit wider so nothing wraps.
    function automatic logic moved_by(input sample_t upper, input sample_t lower,
                                      input sample_t thr);
        logic [SAMPLE_W:0] diff;
        diff = {1'b0, upper} - {1'b0, lower};
        return !diff[SAMPLE_W] && (diff[SAMPLE_W-1:0] >= thr);
    endfunction
endpackage

// File: rtl/xtrk_noise_sel.sv
module xtrk_noise_sel
    import xtrk_pkg::*;
#(
    parameter int unsigned NOISE_NORM = 8'h30,
    parameter int unsigned NOISE_HIGH = 8'h48
) (
    input  logic    gain_max,
    output sample_t thr
);
    localparam sample_t THR_NORM = sample_t'(NOISE_NORM);
    localparam sample_t THR_HIGH = sample_t'(NOISE_HIGH);

    assign thr = gain_max ? THR_HIGH : THR_NORM;
endmodule

// File: rtl/xtrk_search.sv
module xtrk_search
    import xtrk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    smp_vld,
    input  sample_t smp_data,
    input  sample_t thr,
    output commit_t evt
);
    phase_e  phase_q, phase_d;
    sample_t lo_q, lo_d, hi_q, hi_d;

    always_comb begin
        phase_d = phase_q;
        lo_d    = lo_q;
        hi_d    = hi_q;
        evt     = '0;
        if (smp_vld && !clr) begin
            unique case (phase_q)
                PH_EMPTY: begin
                    lo_d    = smp_data;
                    hi_d    = smp_data;
                    phase_d = PH_BOTH;
                end
                PH_BOTH: begin
                    if (moved_by(smp_data, lo_q, thr)) begin
                        evt     = '{hit_min: 1'b1, hit_max: 1'b0, val: lo_q};
                        hi_d    = smp_data;
                        phase_d = PH_SEEK_MAX;
                    end else if (moved_by(hi_q, smp_data, thr)) begin
                        evt     = '{hit_min: 1'b0, hit_max: 1'b1, val: hi_q};
                        lo_d    = smp_data;
                        phase_d = PH_SEEK_MIN;
                    end else begin
                        if (smp_data < lo_q) lo_d = smp_data;
                        if (smp_data > hi_q) hi_d = smp_data;
                    end
                end
                PH_SEEK_MIN: begin
                    if (smp_data < lo_q) begin
                        lo_d = smp_data;
                    end else if (moved_by(smp_data, lo_q, thr)) begin
                        evt     = '{hit_min: 1'b1, hit_max: 1'b0, val: lo_q};
                        hi_d    = smp_data;
                        phase_d = PH_SEEK_MAX;
                    end
                end
                PH_SEEK_MAX: begin
                    if (smp_data > hi_q) begin
                        hi_d = smp_data;
                    end else if (moved_by(hi_q, smp_data, thr)) begin
                        evt     = '{hit_min: 1'b0, hit_max: 1'b1, val: hi_q};
                        lo_d    = smp_data;
                        phase_d = PH_SEEK_MIN;
                    end
                end
                default: phase_d = PH_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= PH_EMPTY;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            phase_q <= phase_d;
            lo_q    <= lo_d;
            hi_q    <= hi_d;
        end
    end
endmodule

// File: rtl/xtrk_commit_regs.sv
module xtrk_commit_regs
    import xtrk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  commit_t evt,
    output sample_t min_val,
    output logic    min_ok,
    output logic    min_stb,
    output sample_t max_val,
    output logic    max_ok,
    output logic    max_stb
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen_q  <= 1'b0;
            min_val <= '0;
            min_ok  <= 1'b0;
            min_stb <= 1'b0;
            max_val <= '0;
            max_ok  <= 1'b0;
            max_stb <= 1'b0;
        end else begin
            min_stb <= evt.hit_min;
            max_stb <= evt.hit_max;
            if (evt.hit_min) begin
                min_val <= evt.val;
                min_ok  <= seen_q;
            end
            if (evt.hit_max) begin
                max_val <= evt.val;
                max_ok  <= seen_q;
            end
            if (evt.hit_min || evt.hit_max) seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/extremum_tracker.sv
module extremum_tracker
    import xtrk_pkg::*;
#(
    parameter int unsigned NOISE_NORM = 8'h30,
    parameter int unsigned NOISE_HIGH = 8'h48
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                gain_max,
    output logic [SAMPLE_W-1:0] min_val,
    output logic                min_ok,
    output logic                min_stb,
    output logic [SAMPLE_W-1:0] max_val,
    output logic                max_ok,
    output logic                max_stb
);
    sample_t thr;
    commit_t evt;

    xtrk_noise_sel #(.NOISE_NORM(NOISE_NORM), .NOISE_HIGH(NOISE_HIGH)) u_thr (
        .gain_max (gain_max),
        .thr      (thr)
    );

    xtrk_search u_search (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .thr      (thr),
        .evt      (evt)
    );

    xtrk_commit_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .evt     (evt),
        .min_val (min_val),
        .min_ok  (min_ok),
        .min_stb (min_stb),
        .max_val (max_val),
        .max_ok  (max_ok),
        .max_stb (max_stb)
    );
endmodule

// File: rtl/xtrk_checker.sv
module xtrk_checker (
    input logic       clk,
    input logic       rst,
    input logic       clr,
    input logic       smp_vld,
    input logic [7:0] min_val,
    input logic       min_ok,
    input logic       min_stb,
    input logic [7:0] max_val,
    input logic       max_ok,
    input logic       max_stb
);
    // Kind of the last commit seen at the ports: 0 none, 1 valley, 2 peak.
    logic [1:0] last_kind;

    always_ff @(posedge clk) begin
        if (rst || clr)   last_kind <= 2'd0;
        else if (min_stb) last_kind <= 2'd1;
        else if (max_stb) last_kind <= 2'd2;
    end

    AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (rst)
        clr |=> (min_val == 8'h00 && max_val == 8'h00 && !min_ok && !max_ok
                 && !min_stb && !max_stb)); // R1
    AST_STB_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> (!min_stb && !max_stb)); // R10
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(min_stb && max_stb)); // R7
    AST_ALTERNATE_MIN: assert property (@(posedge clk) disable iff (rst || clr)
        min_stb |-> last_kind != 2'd1); // R7
    AST_ALTERNATE_MAX: assert property (@(posedge clk) disable iff (rst || clr)
        max_stb |-> last_kind != 2'd2); // R7
    AST_MIN_VALID_TAG: assert property (@(posedge clk) disable iff (rst || clr)
        min_stb |-> min_ok == (last_kind == 2'd2)); // R8
    AST_MAX_VALID_TAG: assert property (@(posedge clk) disable iff (rst || clr)
        max_stb |-> max_ok == (last_kind == 2'd1)); // R8
    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!min_stb && !$past(clr)) |-> ($stable(min_val) && $stable(min_ok))); // R10
    AST_MAX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!max_stb && !$past(clr)) |-> ($stable(max_val) && $stable(max_ok))); // R10
endmodule

bind extremum_tracker xtrk_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .smp_vld (smp_vld),
    .min_val (min_val),
    .min_ok  (min_ok),
    .min_stb (min_stb),
    .max_val (max_val),
    .max_ok  (max_ok),
    .max_stb (max_stb)
);

// File: tb/extremum_tracker_test.sv
`timescale 1ns/1ps
module extremum_tracker_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_data = 8'h00;
    logic       gain_max = 1'b0;
    logic [7:0] min_val, max_val;
    logic       min_ok, min_stb, max_ok, max_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    extremum_tracker uut (
        .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .smp_data(smp_data),
        .gain_max(gain_max), .min_val(min_val), .min_ok(min_ok), .min_stb(min_stb),
        .max_val(max_val), .max_ok(max_ok), .max_stb(max_stb)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Present one sample for one cycle; outputs are looked at on the following negedge.
    task automatic send(input logic [7:0] x);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_data = x;
        @(negedge clk);
        smp_vld  = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Strobes are one cycle wide, so this send samples them right after the sample cycle.
    task automatic send_chk(input string req, input logic [7:0] x,
                            input logic exp_mn, input logic exp_mx);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_data = x;
        @(negedge clk);
        smp_vld  = 1'b0;
        check(req, "min_stb", int'(min_stb), int'(exp_mn));
        check(req, "max_stb", int'(max_stb), int'(exp_mx));
        @(negedge clk);
        check(req, "min_stb one cycle", int'(min_stb), 0);
        check(req, "max_stb one cycle", int'(max_stb), 0);
    endtask

    task automatic do_clear;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic expect_min(input string req, input logic [7:0] v, input logic ok);
        check(req, "min_val", int'(min_val), int'(v));
        check(req, "min_ok", int'(min_ok), int'(ok));
    endtask

    task automatic expect_max(input string req, input logic [7:0] v, input logic ok);
        check(req, "max_val", int'(max_val), int'(v));
        check(req, "max_ok", int'(max_ok), int'(ok));
    endtask

    task automatic t_reset;
        expect_min("R1", 8'h00, 1'b0);
        expect_max("R1", 8'h00, 1'b0);
        check("R1", "strobes", int'({min_stb, max_stb}), 0);
    endtask

    task automatic t_rising_start;
        do_clear();
        gain_max = 1'b0;
        send(8'h50);
        send_chk("R3", 8'h40, 1'b0, 1'b0);
        send_chk("R4", 8'h60, 1'b0, 1'b0);           // 0x20 above the candidate
        send_chk("R4", 8'h70, 1'b1, 1'b0);           // exactly 0x30
        expect_min("R4 R3 R8", 8'h40, 1'b0);         // first commit of the run is invalid
        send_chk("R3", 8'h90, 1'b0, 1'b0);
        send_chk("R5", 8'h61, 1'b0, 1'b0);           // 0x2F below the peak
        expect_max("R10", 8'h00, 1'b0);
        send_chk("R5", 8'h60, 1'b0, 1'b1);
        expect_max("R5 R8", 8'h90, 1'b1);
        expect_min("R10", 8'h40, 1'b0);
        send_chk("R7", 8'h20, 1'b0, 1'b0);
        send_chk("R7", 8'h50, 1'b1, 1'b0);
        expect_min("R7 R8", 8'h20, 1'b1);
    endtask

    task automatic t_falling_start;
        do_clear();
        gain_max = 1'b0;
        send(8'hA0);
        send_chk("R2", 8'h70, 1'b0, 1'b1);
        expect_max("R2 R8", 8'hA0, 1'b0);
        expect_min("R2", 8'h00, 1'b0);
        // R7: the committing sample 0x70 seeds the valley search.
        send_chk("R7", 8'h9F, 1'b0, 1'b0);
        send_chk("R7", 8'hA0, 1'b1, 1'b0);
        expect_min("R7 R8", 8'h70, 1'b1);
    endtask

    task automatic t_high_gain;
        do_clear();
        gain_max = 1'b1;
        send(8'h80);
        send_chk("R6", 8'hC7, 1'b0, 1'b0);           // 0x47 < 0x48
        send_chk("R6", 8'hC8, 1'b1, 1'b0);
        expect_min("R6", 8'h80, 1'b0);
        send_chk("R6", 8'h81, 1'b0, 1'b0);
        send_chk("R6", 8'h80, 1'b0, 1'b1);
        expect_max("R6", 8'hC8, 1'b1);
        gain_max = 1'b0;
    endtask

    task automatic t_edges;
        do_clear();
        gain_max = 1'b0;
        send(8'h10);
        send_chk("R9", 8'hF0, 1'b1, 1'b0);
        send_chk("R9", 8'hFF, 1'b0, 1'b0);
        send_chk("R9", 8'hD0, 1'b0, 1'b0);
        send_chk("R9", 8'h00, 1'b0, 1'b1);
        expect_max("R9", 8'hFF, 1'b1);
        send_chk("R9", 8'h2F, 1'b0, 1'b0);
        send_chk("R9", 8'h30, 1'b1, 1'b0);
        expect_min("R9", 8'h00, 1'b1);
    endtask

    task automatic t_clear;
        // Registers are loaded from t_edges; a clear must flush them.
        @(negedge clk);
        clr      = 1'b1;
        smp_vld  = 1'b1;
        smp_data = 8'h10;                             // dropped: clear wins
        @(negedge clk);
        clr      = 1'b0;
        smp_vld  = 1'b0;
        expect_min("R1", 8'h00, 1'b0);
        expect_max("R1", 8'h00, 1'b0);
        // If 0x10 had seeded, 0x40 would commit a valley.
        send_chk("R1 R2", 8'h40, 1'b0, 1'b0);
        send_chk("R2", 8'h70, 1'b1, 1'b0);
        expect_min("R2 R8", 8'h40, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rising_start();
        t_falling_start();
        t_high_gain();
        t_edges();
        t_clear();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule